// File: doc/BRIEF.md
# Debug Register-Access Scan Register

This block is a 40-bit test-access data register. A debugger uses it to read and write a small bank of configuration and status registers through the standard TAP strobes (capture, shift, update) and serial data, all on the test clock. The block sits between the TAP controller and a register file. It drives the file's address, write data and write strobe, and it takes the file's read data back in.

A single chain carries two frame formats, and bit 0 of the frame picks between them. A frame with bit 0 set is a direct frame. It holds a write/read flag in bit 39 (1 = write, 0 = read), a 6-bit register address in bits 38:33 and a 32-bit value in bits 32:1. A direct write commits when the TAP passes through update. A direct read only arms the block at update. The value comes out on the next capture/shift pass. A frame with bit 0 clear is an instruction frame. Its bits 32:1 are latched for another unit to execute later, and only while the interpret enable (bit 0 of the test-state register) is set.

A three-state controller tracks the scan. `ST_IDLE` is entered after reset or after any update that is not a direct read. `ST_SCAN` is entered on a capture. `ST_RDARM` is entered on an update that carries a direct read. A capture in `ST_RDARM` loads the read-back frame and moves to `ST_SCAN`. A capture in any other state loads zeros.

Top module: `dbg_regscan_dr`

## Requirements
- R1: While `sel` and `shift_dr` are high, each rising `tck` shifts the chain one place toward bit 0, with `tdi` entering bit 39. `tdo` always shows bit 0 of the chain.
- R2: Direct frame layout: bit 0 = 1, bit 39 = write flag (1 write, 0 read), bits 38:33 = address, bits 32:1 = value. Instruction frame: bit 0 = 0, bits 32:1 = instruction word.
- R3: At update, a direct write frame whose address is writable (0x02 control, 0x1A process tag, 0x1E test state) raises `rf_we` for that cycle, with `rf_addr` and `rf_wdata` taken from the frame.
- R4: A direct write frame to a read-only address (0x00, 0x01, 0x12, 0x13) or to any unmapped address raises no `rf_we`.
- R5: After an update carrying a direct read frame, the next capture loads `{0, address, rf_rdata, 1}` into the chain, with `rf_addr` holding the read address.
- R6: A direct read of an unmapped address returns value zero in bits 32:1.
- R7: A capture that does not follow a direct read loads all zeros.
- R8: `interp_en` is 0 after reset and takes bit 1 of the frame (value bit 0) whenever a direct write to 0x1E commits.
- R9: An instruction frame at update while `interp_en` is 1 loads bits 32:1 into `instr_word` and pulses `instr_vld` high for one cycle. It writes nothing to the register file.
- R10: An instruction frame at update while `interp_en` is 0 leaves `instr_word` unchanged and raises no `instr_vld`.
- R11: While `trst_n` is low, `tdo`, `rf_we`, `interp_en`, `instr_vld` and `instr_word` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | This data register is the one selected |
| capture_dr | input | 1 | TAP is in the capture state |
| shift_dr | input | 1 | TAP is in the shift state |
| update_dr | input | 1 | TAP is in the update state |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| rf_addr | output | 6 | Register-file address |
| rf_wdata | output | 32 | Register-file write data |
| rf_we | output | 1 | Register-file write strobe |
| rf_rdata | input | 32 | Register-file read data for `rf_addr` |
| interp_en | output | 1 | Interpret enable copy of test-state bit 0 |
| instr_word | output | 32 | Latched instruction word |
| instr_vld | output | 1 | One-cycle pulse when a new instruction word is latched |

## Verification
If the controller state is wrong, the fault shows one whole scan later. A lost `ST_RDARM` turns a read-back frame into zeros, and a stale one replaces the zeros expected after a write. A bad address hold or a bad decode shows up as a write strobe aimed at a protected register, or as a nonzero read of an unmapped address. Both can be seen within the same update cycle or on the next capture. A wrong interpret copy changes whether `instr_vld` pulses one cycle after the next instruction frame's update.

// File: rtl/dbgdr_pkg.sv
package dbgdr_pkg;
    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 32;
    localparam int FRAME_W = DATA_W + ADDR_W + 2;
    localparam int VAL_LO  = 1;
    localparam int VAL_HI  = VAL_LO + DATA_W - 1;
    localparam int ADR_LO  = VAL_HI + 1;
    localparam int ADR_HI  = ADR_LO + ADDR_W - 1;
    localparam int WR_BIT  = ADR_HI + 1;

    localparam logic [ADDR_W-1:0] A_IDENT  = 6'h00;
    localparam logic [ADDR_W-1:0] A_CTYPE  = 6'h01;
    localparam logic [ADDR_W-1:0] A_CTRL   = 6'h02;
    localparam logic [ADDR_W-1:0] A_DLOCK  = 6'h12;
    localparam logic [ADDR_W-1:0] A_ILOCK  = 6'h13;
    localparam logic [ADDR_W-1:0] A_PTAG   = 6'h1A;
    localparam logic [ADDR_W-1:0] A_TSTATE = 6'h1E;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_RDARM = 2'd2
    } dr_state_t;
endpackage

// File: rtl/dbgdr_chain.sv
module dbgdr_chain #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_en,
    input  logic [W-1:0] cap_val,
    input  logic         shift_en,
    input  logic         sin,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (cap_en)
            q <= cap_val;
        else if (shift_en)
            q <= {sin, q[W-1:1]};
    end
endmodule

// File: rtl/dbgdr_decode.sv
module dbgdr_decode
    import dbgdr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic              mapped,
    output logic              writable
);
    always_comb begin
        unique case (addr)
            A_CTRL, A_PTAG, A_TSTATE: begin
                mapped   = 1'b1;
                writable = 1'b1;
            end
            A_IDENT, A_CTYPE, A_DLOCK, A_ILOCK: begin
                mapped   = 1'b1;
                writable = 1'b0;
            end
            default: begin
                mapped   = 1'b0;
                writable = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/dbg_regscan_dr.sv
module dbg_regscan_dr
    import dbgdr_pkg::*;
(
    input  logic              tck,
    input  logic              trst_n,
    input  logic              sel,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              rf_we,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              interp_en,
    output logic [DATA_W-1:0] instr_word,
    output logic              instr_vld
);
    logic [FRAME_W-1:0] chain_q;
    logic [FRAME_W-1:0] cap_frame;
    logic [ADDR_W-1:0]  addr_q;
    logic               interp_q;
    logic [DATA_W-1:0]  instr_q;
    logic               vld_q;
    dr_state_t          state_q, state_d;

    logic do_cap, do_shift, do_upd;
    logic f_direct, f_write;
    logic [ADDR_W-1:0] f_addr;
    logic [DATA_W-1:0] f_val;
    logic is_mapped, is_writable;
    logic rd_arm, wr_commit, ins_issue;

    assign do_cap   = sel & capture_dr;
    assign do_shift = sel & shift_dr;
    assign do_upd   = sel & update_dr;

    assign f_direct = chain_q[0];
    assign f_write  = chain_q[WR_BIT];
    assign f_addr   = chain_q[ADR_HI:ADR_LO];
    assign f_val    = chain_q[VAL_HI:VAL_LO];

    dbgdr_chain #(.W(FRAME_W)) u_chain (
        .clk      (tck),
        .rst_n    (trst_n),
        .cap_en   (do_cap),
        .cap_val  (cap_frame),
        .shift_en (do_shift),
        .sin      (tdi),
        .q        (chain_q)
    );

    dbgdr_decode u_dec (
        .addr     (rf_addr),
        .mapped   (is_mapped),
        .writable (is_writable)
    );

    // state register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        rd_arm  = do_upd & f_direct & ~f_write;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (do_upd)      state_d = rd_arm ? ST_RDARM : ST_IDLE;
                else if (do_cap) state_d = ST_SCAN;
            end
            ST_SCAN: begin
                if (do_upd)      state_d = rd_arm ? ST_RDARM : ST_IDLE;
                else if (do_cap) state_d = ST_SCAN;
            end
            ST_RDARM: begin
                if (do_upd)      state_d = rd_arm ? ST_RDARM : ST_IDLE;
                else if (do_cap) state_d = ST_SCAN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rf_addr   = do_upd ? f_addr : addr_q;
        rf_wdata  = f_val;
        wr_commit = do_upd & f_direct & f_write;
        rf_we     = wr_commit & is_writable;
        ins_issue = do_upd & ~f_direct & interp_q;
        unique case (state_q)
            ST_RDARM: cap_frame = {1'b0, addr_q,
                                   (is_mapped ? rf_rdata : {DATA_W{1'b0}}), 1'b1};
            default:  cap_frame = '0;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            addr_q   <= '0;
            interp_q <= 1'b0;
            instr_q  <= '0;
            vld_q    <= 1'b0;
        end else begin
            vld_q <= ins_issue;
            if (do_upd && f_direct)
                addr_q <= f_addr;
            if (rf_we && (f_addr == A_TSTATE))
                interp_q <= f_val[0];
            if (ins_issue)
                instr_q <= f_val;
        end
    end

    assign tdo        = chain_q[0];
    assign interp_en  = interp_q;
    assign instr_word = instr_q;
    assign instr_vld  = vld_q;
endmodule

// File: rtl/dbgdr_chk.sv
module dbgdr_chk
    import dbgdr_pkg::*;
(
    input logic              tck,
    input logic              trst_n,
    input logic              sel,
    input logic              update_dr,
    input logic              frame_b0,
    input logic [ADDR_W-1:0] rf_addr,
    input logic              rf_we,
    input logic              interp_en,
    input logic [DATA_W-1:0] instr_word,
    input logic              instr_vld
);
    // R3
    we_on_update_chk: assert property (@(posedge tck) disable iff (!trst_n)
        rf_we |-> (sel && update_dr));

    // R4
    we_target_chk: assert property (@(posedge tck) disable iff (!trst_n)
        rf_we |-> (rf_addr == 6'h02 || rf_addr == 6'h1A || rf_addr == 6'h1E));

    // R9
    instr_latch_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (sel && update_dr && !frame_b0 && interp_en) |=> instr_vld);

    // R10
    instr_gate_chk: assert property (@(posedge tck) disable iff (!trst_n)
        instr_vld |-> $past(interp_en));

    // R9
    word_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(instr_word) |-> instr_vld);

    // R8
    interp_src_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(interp_en) |-> $past(rf_we && rf_addr == 6'h1E));
endmodule

bind dbg_regscan_dr dbgdr_chk u_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .sel        (sel),
    .update_dr  (update_dr),
    .frame_b0   (chain_q[0]),
    .rf_addr    (rf_addr),
    .rf_we      (rf_we),
    .interp_en  (interp_en),
    .instr_word (instr_word),
    .instr_vld  (instr_vld)
);

// File: tb/test_dbg_regscan_dr.sv
module test_dbg_regscan_dr;
    localparam int TCK_PERIOD = 10;
    localparam int NVEC = 8;

    typedef struct packed {
        logic [5:0]  addr;
        logic [31:0] wdata;
        logic [31:0] expect_rd;
        logic        wr_ok;
    } vec_t;

    // R3 writable, R4 read-only/unmapped, R6 unmapped read zero
    localparam vec_t VEC [NVEC] = '{
        '{6'h02, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1},
        '{6'h1A, 32'h1234_5678, 32'h1234_5678, 1'b1},
        '{6'h00, 32'hFFFF_FFFF, 32'hC0DE_0000, 1'b0},
        '{6'h3F, 32'h0000_FFFF, 32'h0000_0000, 1'b0},
        '{6'h01, 32'h5555_AAAA, 32'hC0DE_0001, 1'b0},
        '{6'h12, 32'h0F0F_0F0F, 32'hC0DE_0012, 1'b0},
        '{6'h1E, 32'h0000_0000, 32'h0000_0000, 1'b1},
        '{6'h20, 32'h8000_0001, 32'h0000_0000, 1'b0}
    };

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic sel = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic tdo, rf_we, interp_en, instr_vld;
    logic [5:0]  rf_addr;
    logic [31:0] rf_wdata, rf_rdata, instr_word;

    logic [31:0] model [64];
    int wr_cnt = 0, vld_cnt = 0, n_chk = 0, n_bad = 0, cyc = 0;

    always #(TCK_PERIOD/2) tck = ~tck;

    dbg_regscan_dr i_dbg_regscan_dr (
        .tck(tck), .trst_n(trst_n), .sel(sel), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
        .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_rdata(rf_rdata),
        .interp_en(interp_en), .instr_word(instr_word), .instr_vld(instr_vld)
    );

    assign rf_rdata = model[rf_addr];

    initial for (int a = 0; a < 64; a++) model[a] = 32'hC0DE_0000 | a;

    always @(posedge tck) begin
        cyc++;
        if (rf_we) begin
            wr_cnt++;
            model[rf_addr] = rf_wdata;
        end
        if (instr_vld) vld_cnt++;
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        wait (cyc > 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual cycles %0d expected < 20000", cyc);
        summary();
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [39:0] dframe(input logic w, input logic [5:0] a, input logic [31:0] d);
        return {w, a, d, 1'b1};
    endfunction

    function automatic logic [39:0] iframe(input logic [31:0] word);
        return {1'b0, 6'h00, word, 1'b0};
    endfunction

    // R1: bits go in LSB first at tdi, and come out LSB first at tdo
    task automatic scan(input logic [39:0] fin, output logic [39:0] fout);
        @(negedge tck); sel = 1'b1; capture_dr = 1'b1;
        @(negedge tck); capture_dr = 1'b0; shift_dr = 1'b1;
        for (int i = 0; i < 40; i++) begin
            fout[i] = tdo;
            tdi = fin[i];
            @(negedge tck);
        end
        shift_dr = 1'b0; update_dr = 1'b1;
        @(negedge tck); update_dr = 1'b0;
        @(negedge tck);
    endtask

    initial begin
        logic [39:0] got;
        int w0, v0;
        repeat (3) @(negedge tck);
        // R11 reset state
        check("R11 tdo", 64'(tdo), 64'd0);
        check("R11 outputs", {rf_we, interp_en, instr_vld, instr_word}, 64'd0);
        trst_n = 1'b1;
        @(negedge tck);

        // table: write, arm read, read back
        for (int k = 0; k < NVEC; k++) begin
            w0 = wr_cnt;
            scan(dframe(1'b1, VEC[k].addr, VEC[k].wdata), got);
            check("R3/R4 write strobe count", 64'(wr_cnt), 64'(w0 + int'(VEC[k].wr_ok)));
            scan(dframe(1'b0, VEC[k].addr, 32'h0), got);
            scan(dframe(1'b0, VEC[k].addr, 32'h0), got);
            check("R5/R6/R2/R1 readback frame", 64'(got), 64'({1'b0, VEC[k].addr, VEC[k].expect_rd, 1'b1}));
        end

        // R7: capture after a write scan loads zeros
        scan(dframe(1'b1, 6'h02, 32'hA5A5_A5A5), got);
        scan(dframe(1'b1, 6'h1A, 32'h0BAD_F00D), got);
        check("R7 capture without read", 64'(got), 64'd0);

        // R10: instruction frame while interpret disabled
        v0 = vld_cnt;
        scan(iframe(32'hEE00_F10F), got);
        repeat (2) @(negedge tck);
        check("R10 no pulse", 64'(vld_cnt), 64'(v0));
        check("R10 word kept", 64'(instr_word), 64'd0);

        // R8: set interpret through test-state write
        scan(dframe(1'b1, 6'h1E, 32'h0000_0001), got);
        check("R8 interp set", 64'(interp_en), 64'd1);

        // R9: latch instruction, no register write
        v0 = vld_cnt; w0 = wr_cnt;
        scan(iframe(32'hEE00_F10F), got);
        repeat (2) @(negedge tck);
        check("R9 one pulse", 64'(vld_cnt), 64'(v0 + 1));
        check("R9 word", 64'(instr_word), 64'hEE00_F10F);
        check("R9 no rf write", 64'(wr_cnt), 64'(w0));

        // R8: clear interpret
        scan(dframe(1'b1, 6'h1E, 32'h0000_0000), got);
        check("R8 interp clear", 64'(interp_en), 64'd0);

        summary();
    end
endmodule